// File: doc/BRIEF.md
# Arithmetic Logic Unit with Status Flags

This block is a 32-bit arithmetic and logic unit for an integer execution path. Each cycle it takes two operands, a 3-bit operation code and an incoming carry bit. It computes add, add with carry, subtract, subtract with borrow, AND, OR or XOR. Along with the result it derives six status bits: carry, overflow, sign, zero, nibble (auxiliary) carry and even parity.

The result leaves through an optional output register, selected by the `REG_OUT` parameter (default 1). The six status bits are captured into a flags register only in cycles where `flagWe` is high. In all other cycles that register keeps its old contents, while the result path keeps updating.

Internally, a small decoder turns the operation code into a struct of strobes: invert B, use carry-in, logic class, and logic select. A datapath module consumes those strobes and produces the result and the raw flags.

Top module: `flag_alu`

## Requirements
- R1: Code 0 (add) gives A+B and code 1 (add with carry) gives A+B+carryIn, both modulo 2^32. The carry flag is the carry out of bit 31.
- R2: Code 2 (subtract) gives A-B and code 3 (subtract with borrow) gives A-B-carryIn, both modulo 2^32. The carry flag is 1 exactly when unsigned A < B + borrow-in.
- R3: For add classes, overflow is 1 when A and B share a sign and the result's sign differs from it. For subtract classes, overflow is 1 when A and B differ in sign and the result's sign differs from A's.
- R4: The sign flag equals bit 31 of the result.
- R5: The zero flag is 1 exactly when all 32 result bits are 0.
- R6: For arithmetic codes, the auxiliary flag is 1 when bits 3..0 produce a carry into bit 4 (add) or need a borrow from bit 4 (subtract).
- R7: The parity flag is 1 when result bits 7..0 contain an even number of ones. Bits above 7 are not counted.
- R8: Code 4 gives A&B, code 5 gives A|B and code 6 gives A^B. For these codes carry, overflow and auxiliary flags are all 0.
- R9: With `flagWe` low, the flags register keeps its value, while the result output still reflects the new operation.
- R10: While `rstN` is low, the result register and all six flags are 0.
- R11: Code 7 gives a result of 0 and follows the logic-class flag rules.
- R12: `carryIn` has no effect on codes 0, 2, 4, 5, 6 and 7.
- R13: With `REG_OUT`=1, the result and the flags written in a cycle both appear after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opCode | input | 3 | Operation select (0 add, 1 add with carry, 2 sub, 3 sub with borrow, 4 and, 5 or, 6 xor, 7 zero) |
| carryIn | input | 1 | Incoming carry/borrow for codes 1 and 3 |
| flagWe | input | 1 | Capture the flags this cycle |
| result | output | 32 | Operation result |
| carryFlag | output | 1 | Unsigned out-of-range / borrow |
| overflowFlag | output | 1 | Signed out-of-range |
| signFlag | output | 1 | Result bit 31 |
| zeroFlag | output | 1 | Result is all zeros |
| auxFlag | output | 1 | Nibble carry or borrow |
| parityFlag | output | 1 | Low byte has even ones count |

## Verification
Several input patterns are used, and each one separates a different class of fault.

- Random operands spread over all eight codes, with `flagWe` toggled at random, separate the add path from the subtract path and the flag-hold path from the write path.
- Operands at the signed and unsigned edges (0x7FFFFFFF, 0x80000000, 0xFFFFFFFF, 0) tell carry apart from overflow, and borrow apart from no borrow.
- Nibble-boundary values such as 0x0F+0x01 and 0x10-0x01 isolate the auxiliary carry.
- A result of 0x100 shows that parity ignores bits above the low byte.
- Repeating a code with both carryIn values shows which codes consume the carry.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBB  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_ZERO = 3'd7
  } aluOp_t;

  typedef enum logic [1:0] {
    LG_AND  = 2'd0,
    LG_OR   = 2'd1,
    LG_XOR  = 2'd2,
    LG_ZERO = 2'd3
  } logicSel_t;

  typedef struct packed {
    logic      invB;      // subtract class
    logic      useCarry;  // consume carryIn
    logic      isLogic;   // logic class
    logicSel_t logicSel;
  } aluStrobe_t;

  typedef struct packed {
    logic cf;
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
  } aluFlags_t;

endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
(
  input  logic [2:0] opCode,
  output aluStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    unique case (aluOp_t'(opCode))
      OP_ADD:  strobe = '{invB: 1'b0, useCarry: 1'b0, isLogic: 1'b0, logicSel: LG_AND};
      OP_ADC:  strobe = '{invB: 1'b0, useCarry: 1'b1, isLogic: 1'b0, logicSel: LG_AND};
      OP_SUB:  strobe = '{invB: 1'b1, useCarry: 1'b0, isLogic: 1'b0, logicSel: LG_AND};
      OP_SBB:  strobe = '{invB: 1'b1, useCarry: 1'b1, isLogic: 1'b0, logicSel: LG_AND};
      OP_AND:  strobe = '{invB: 1'b0, useCarry: 1'b0, isLogic: 1'b1, logicSel: LG_AND};
      OP_OR:   strobe = '{invB: 1'b0, useCarry: 1'b0, isLogic: 1'b1, logicSel: LG_OR};
      OP_XOR:  strobe = '{invB: 1'b0, useCarry: 1'b0, isLogic: 1'b1, logicSel: LG_XOR};
      default: strobe = '{invB: 1'b0, useCarry: 1'b0, isLogic: 1'b1, logicSel: LG_ZERO};
    endcase
  end

  // R8 / R12: logic class never inverts B nor consumes carry
  always_comb begin
    assert_ctrl_excl_R8: assert (!(strobe.isLogic && (strobe.invB || strobe.useCarry)));
  end

endmodule

// File: rtl/flag_alu_datapath.sv
module flag_alu_datapath
  import flag_alu_pkg::*;
#(
  parameter int W        = 32,
  parameter int NIB      = 4,
  parameter int PAR_BITS = 8
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  input  aluStrobe_t   strobe,
  output logic [W-1:0] resNext,
  output aluFlags_t    flagsNext
);

  localparam int MSB = W - 1;

  logic [W-1:0]   bEff;
  logic           cinEff;
  logic [W:0]     sumWide;
  logic [NIB:0]   nibSum;
  logic [W-1:0]   logicRes;
  logic           arithCarry;
  logic           arithOvf;
  logic           arithAux;

  always_comb begin
    bEff   = strobe.invB ? ~opB : opB;
    // subtract: A + ~B + 1 - borrow
    cinEff = strobe.invB ? ~(strobe.useCarry & carryIn) : (strobe.useCarry & carryIn);
    sumWide = {1'b0, opA} + {1'b0, bEff} + {{W{1'b0}}, cinEff};
    nibSum  = {1'b0, opA[NIB-1:0]} + {1'b0, bEff[NIB-1:0]} + {{NIB{1'b0}}, cinEff};
    arithCarry = strobe.invB ? ~sumWide[W] : sumWide[W];
    arithAux   = strobe.invB ? ~nibSum[NIB] : nibSum[NIB];
    arithOvf   = (opA[MSB] == bEff[MSB]) && (sumWide[MSB] != opA[MSB]);
  end

  always_comb begin
    unique case (strobe.logicSel)
      LG_AND:  logicRes = opA & opB;
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      default: logicRes = '0;
    endcase
  end

  always_comb begin
    resNext      = strobe.isLogic ? logicRes : sumWide[W-1:0];
    flagsNext.cf = strobe.isLogic ? 1'b0 : arithCarry;
    flagsNext.of = strobe.isLogic ? 1'b0 : arithOvf;
    flagsNext.af = strobe.isLogic ? 1'b0 : arithAux;
    flagsNext.sf = resNext[MSB];
    flagsNext.zf = (resNext == '0);
    flagsNext.pf = ~^resNext[PAR_BITS-1:0];
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W        = 32,
  parameter bit REG_OUT  = 1'b1,
  parameter int PAR_BITS = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [2:0]   opCode,
  input  logic         carryIn,
  input  logic         flagWe,
  output logic [W-1:0] result,
  output logic         carryFlag,
  output logic         overflowFlag,
  output logic         signFlag,
  output logic         zeroFlag,
  output logic         auxFlag,
  output logic         parityFlag
);

  aluStrobe_t strobe;
  logic [W-1:0] resNext;
  aluFlags_t    flagsNext;
  aluFlags_t    flagsQ;

  flag_alu_ctrl u_ctrl (
    .opCode (opCode),
    .strobe (strobe)
  );

  flag_alu_datapath #(
    .W        (W),
    .NIB      (4),
    .PAR_BITS (PAR_BITS)
  ) u_dp (
    .opA       (opA),
    .opB       (opB),
    .carryIn   (carryIn),
    .strobe    (strobe),
    .resNext   (resNext),
    .flagsNext (flagsNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN)       flagsQ <= '0;
    else if (flagWe) flagsQ <= flagsNext;
  end

  generate
    if (REG_OUT) begin : g_regOut
      logic [W-1:0] resQ;
      always_ff @(posedge clk) begin
        if (!rstN) resQ <= '0;
        else       resQ <= resNext;
      end
      assign result = resQ;

      // R4 / R5 / R7: a flags write lines up with the registered result
      assert_sign_match_R4: assert property (@(posedge clk) disable iff (!rstN)
        flagWe |=> (flagsQ.sf == resQ[W-1]));
      assert_zero_match_R5: assert property (@(posedge clk) disable iff (!rstN)
        flagWe |=> (flagsQ.zf == (resQ == '0)));
      assert_parity_match_R7: assert property (@(posedge clk) disable iff (!rstN)
        flagWe |=> (flagsQ.pf == ~^resQ[PAR_BITS-1:0]));
    end else begin : g_combOut
      assign result = resNext;
    end
  endgenerate

  assign carryFlag    = flagsQ.cf;
  assign overflowFlag = flagsQ.of;
  assign signFlag     = flagsQ.sf;
  assign zeroFlag     = flagsQ.zf;
  assign auxFlag      = flagsQ.af;
  assign parityFlag   = flagsQ.pf;

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !flagWe |=> $stable(flagsQ));
  assert_logic_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (flagWe && strobe.isLogic) |=> (!flagsQ.cf && !flagsQ.of && !flagsQ.af));

endmodule

// File: tb/flag_alu_tb.sv
module flag_alu_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] opA, opB;
  logic [2:0]  opCode;
  logic        carryIn, flagWe;
  logic [31:0] result;
  logic        carryFlag, overflowFlag, signFlag, zeroFlag, auxFlag, parityFlag;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [5:0]  expFlags; // {cf,of,sf,zf,af,pf}
  logic [31:0] expRes;

  always #4 clk = ~clk;

  flag_alu u_dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opCode(opCode),
    .carryIn(carryIn), .flagWe(flagWe), .result(result),
    .carryFlag(carryFlag), .overflowFlag(overflowFlag), .signFlag(signFlag),
    .zeroFlag(zeroFlag), .auxFlag(auxFlag), .parityFlag(parityFlag)
  );

  function automatic logic [37:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [2:0] op, input logic ci);
    logic [32:0] wide;
    logic [31:0] r;
    logic cf, of, af, bi;
    int ones;
    cf = 0; of = 0; af = 0; r = '0;
    case (op)
      3'd0, 3'd1: begin
        bi = (op == 3'd1) ? ci : 1'b0;
        wide = {1'b0, a} + {1'b0, b} + {32'd0, bi};
        r = wide[31:0]; cf = wide[32];
        af = ({1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, bi}) > 5'd15;
        of = (a[31] == b[31]) && (r[31] != a[31]);
      end
      3'd2, 3'd3: begin
        bi = (op == 3'd3) ? ci : 1'b0;
        r = a - b - {31'd0, bi};
        cf = ({1'b0, a} < ({1'b0, b} + {32'd0, bi}));
        af = ({1'b0, a[3:0]} < ({1'b0, b[3:0]} + {4'd0, bi}));
        of = (a[31] != b[31]) && (r[31] != a[31]);
      end
      3'd4: r = a & b;
      3'd5: r = a | b;
      3'd6: r = a ^ b;
      default: r = '0;
    endcase
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(r[i]);
    return {r, cf, of, r[31], (r == 0), af, ((ones % 2) == 0)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string resTag(input logic [2:0] op);
    if (op <= 3'd1) return "R1 result";
    if (op <= 3'd3) return "R2 result";
    if (op == 3'd7) return "R11 result";
    return "R8 result";
  endfunction

  // drive at negedge, capture at posedge, check at following negedge (R13)
  task automatic runOp(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op,
                       input logic ci, input logic we);
    logic [37:0] m;
    logic [5:0] actF;
    opA = a; opB = b; opCode = op; carryIn = ci; flagWe = we;
    m = model(a, b, op, ci);
    expRes = m[37:6];
    if (we) expFlags = m[5:0];
    @(posedge clk);
    @(negedge clk);
    actF = {carryFlag, overflowFlag, signFlag, zeroFlag, auxFlag, parityFlag};
    check(resTag(op), result, expRes);
    if (!we) check("R9 flags held", {26'd0, actF}, {26'd0, expFlags});
    else begin
      check((op >= 3'd4) ? "R8 carry" : (op >= 3'd2 ? "R2 carry" : "R1 carry"),
            {31'd0, carryFlag}, {31'd0, expFlags[5]});
      check("R3 overflow", {31'd0, overflowFlag}, {31'd0, expFlags[4]});
      check("R4 sign",     {31'd0, signFlag},     {31'd0, expFlags[3]});
      check("R5 zero",     {31'd0, zeroFlag},     {31'd0, expFlags[2]});
      check("R6 aux",      {31'd0, auxFlag},      {31'd0, expFlags[1]});
      check("R7 parity",   {31'd0, parityFlag},   {31'd0, expFlags[0]});
    end
  endtask

  initial begin
    int seedDummy;
    rstN = 1'b0; opA = '1; opB = '1; opCode = 3'd0; carryIn = 1'b1; flagWe = 1'b1;
    expFlags = '0;
    seedDummy = $urandom(32'h5eed_1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset result", result, 32'd0);
    check("R10 reset flags", {26'd0, carryFlag, overflowFlag, signFlag, zeroFlag, auxFlag, parityFlag}, 32'd0);
    rstN = 1'b1;

    // directed corners
    runOp(32'h7FFF_FFFF, 32'h1, 3'd0, 1'b0, 1'b1);   // R3 signed overflow add
    runOp(32'hFFFF_FFFF, 32'h1, 3'd0, 1'b0, 1'b1);   // R1 carry, R5 zero
    runOp(32'hFFFF_FFFF, 32'h0, 3'd1, 1'b1, 1'b1);   // R1 adc wraps
    runOp(32'h0000_000F, 32'h1, 3'd0, 1'b1, 1'b1);   // R6 nibble carry, R12 ci ignored
    runOp(32'h0, 32'h1, 3'd2, 1'b0, 1'b1);           // R2 borrow
    runOp(32'h5, 32'h5, 3'd3, 1'b1, 1'b1);           // R2 sbb borrow from carry
    runOp(32'h5, 32'h5, 3'd2, 1'b1, 1'b1);           // R12 ci ignored on sub
    runOp(32'h8000_0000, 32'h1, 3'd2, 1'b0, 1'b1);   // R3 sub overflow
    runOp(32'h10, 32'h1, 3'd2, 1'b0, 1'b1);          // R6 nibble borrow
    runOp(32'h0000_00FF, 32'h1, 3'd0, 1'b0, 1'b1);   // R7 result 0x100 parity on low byte
    runOp(32'hF0F0_F0F0, 32'hFFFF_0000, 3'd4, 1'b1, 1'b1); // R8 and
    runOp(32'hFFFF_FFFF, 32'h1, 3'd0, 1'b0, 1'b1);   // set cf then hold
    runOp(32'h1234_5678, 32'h0, 3'd6, 1'b0, 1'b0);   // R9 result updates, flags held
    runOp(32'hDEAD_BEEF, 32'h1, 3'd7, 1'b1, 1'b1);   // R11 zero code

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, b;
      logic [2:0] op;
      a = $urandom(); b = $urandom();
      if (n % 5 == 0) a[31:28] = b[31:28];
      if (n % 7 == 0) b = a;
      op = 3'($urandom_range(7));
      runOp(a, b, op, 1'($urandom()), ($urandom_range(3) != 0));
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule